// File: doc/BRIEF.md
# Short-Distance Shift and Rotate Unit

This unit shifts or rotates an 8-, 16- or 32-bit operand by one or two bit positions and produces the sized result together with the negative, zero, overflow and carry flags. It is meant to sit in the execute stage of a small processor. The operation, the operand size and the incoming carry come from the decoder. The distance comes from a single bit of the control byte that accompanies the instruction.

Eight operations are offered: logical, arithmetic and plain rotates in both directions, and rotates through carry in both directions. A two-position operation gives exactly the result and flags of the one-position operation applied twice in a row. For the arithmetic left shift, V is set when the sign bit changes during the operation. Result and flags are registered, so they appear one clock after the inputs.

Top module: `shrot_unit`

## Requirements
- R1: Result and all four flags are registered and reflect the inputs present at the previous rising clock edge. While rst_ni is low, every output is 0.
- R2: Bit 6 of ctrl_i selects the distance: 0 moves one position and 1 moves two. The other ctrl_i bits have no effect. A two-position operation equals the one-position operation applied twice, with the carry of the first step fed to the second.
- R3: op_i = 0 is a logical left shift. Zero enters bit 0, C takes the last bit that leaves the top bit, and V is 0.
- R4: op_i = 1 is a logical right shift. Zero enters the top bit, C takes the last bit that leaves bit 0, and V is 0.
- R5: op_i = 2 is an arithmetic left shift. Zero enters bit 0 and C takes the last bit that leaves the top bit. V is 1 when any bit that passes through the sign position differs from the final sign. For one step, V is set when the top two bits of the operand differ. For two steps, it is set when the top three bits are not all equal.
- R6: op_i = 3 is an arithmetic right shift. The sign bit is copied into the vacated top positions, C takes the last bit that leaves bit 0, and V is 0.
- R7: op_i = 4 rotates left and op_i = 5 rotates right. The bit leaving one end enters the other end and is also copied to C. V is 0.
- R8: op_i = 6 rotates left through carry and op_i = 7 rotates right through carry. c_i enters the vacated end, the bit leaving goes to C, and V is 0.
- R9: size_i = 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. The top bit is 7, 15 or 31. Operand bits above the size are ignored, and result bits above the size are 0.
- R10: N equals the top bit of the sized result. Z is 1 exactly when the sized result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | 32 | Value to shift or rotate |
| size_i | input | 2 | Operand size code |
| op_i | input | 3 | Operation code |
| ctrl_i | input | 8 | Control byte; bit 6 selects the distance |
| c_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Sized result, zero above the size |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The bench uses the default parameters: widths of 8, 16 and 32 and distance-select bit 6. This lets it reach every size boundary, including the top-bit position and the masking of upper bits at each width. Random operands with random junk above the selected size are mixed with directed cases. These cover sign-change overflow on one- and two-step arithmetic left shifts, carry entering on rotate-through-carry, and control bytes in which every bit except bit 6 is toggled.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASL = 3'd2,
    OP_ASR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } shrot_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } shrot_size_e;
endpackage

// File: rtl/shrot_size_dec.sv
module shrot_size_dec #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int LONG_W = 32
) (
  input  logic [1:0]        size_i,
  output logic [LONG_W-1:0] mask_o,
  output logic [LONG_W-1:0] msb_oh_o
);
  import shrot_pkg::*;

  localparam logic [LONG_W-1:0] ONE = LONG_W'(1);

  always_comb begin
    unique case (shrot_size_e'(size_i))
      SZ_BYTE: begin
        mask_o   = (ONE << BYTE_W) - ONE;
        msb_oh_o = ONE << (BYTE_W - 1);
      end
      SZ_WORD: begin
        mask_o   = (ONE << WORD_W) - ONE;
        msb_oh_o = ONE << (WORD_W - 1);
      end
      default: begin
        mask_o   = '1;
        msb_oh_o = ONE << (LONG_W - 1);
      end
    endcase
  end
endmodule

// File: rtl/shrot_step.sv
module shrot_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] msb_oh_i,
  input  logic [2:0]   op_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);
  import shrot_pkg::*;

  logic         top_b, sub_b, bot_b;
  logic [W-1:0] left_v, right_v;

  assign top_b   = |(a_i & msb_oh_i);
  assign sub_b   = |(a_i & (msb_oh_i >> 1));
  assign bot_b   = a_i[0];
  assign left_v  = (a_i << 1) & mask_i;
  assign right_v = (a_i & mask_i) >> 1;

  always_comb begin
    res_o = left_v;
    c_o   = top_b;
    v_o   = 1'b0;
    unique case (shrot_op_e'(op_i))
      OP_LSL: ;
      OP_LSR: begin res_o = right_v; c_o = bot_b; end
      OP_ASL: v_o = top_b ^ sub_b;
      OP_ASR: begin
        res_o = right_v | (top_b ? msb_oh_i : '0);
        c_o   = bot_b;
      end
      OP_ROL: res_o = left_v | W'(top_b);
      OP_ROR: begin
        res_o = right_v | (bot_b ? msb_oh_i : '0);
        c_o   = bot_b;
      end
      OP_RCL: res_o = left_v | W'(c_i);
      OP_RCR: begin
        res_o = right_v | (c_i ? msb_oh_i : '0);
        c_o   = bot_b;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] msb_oh_i,
  output logic         n_o,
  output logic         z_o
);
  assign n_o = |(res_i & msb_oh_i);
  assign z_o = ~|(res_i & mask_i);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int BYTE_W   = 8,
  parameter int WORD_W   = 16,
  parameter int LONG_W   = 32,
  parameter int CTRL_W   = 8,
  parameter int DIST_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LONG_W-1:0] operand_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        op_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              c_i,
  output logic [LONG_W-1:0] result_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int MAX_STEP = 2;

  logic [LONG_W-1:0] mask, msb_oh;
  logic [LONG_W-1:0] st_in  [MAX_STEP+1];
  logic              st_c   [MAX_STEP+1];
  logic              st_v   [MAX_STEP];
  logic              two_step;
  logic [LONG_W-1:0] res_d;
  logic              c_d, v_d, n_d, z_d;

  shrot_size_dec #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .LONG_W(LONG_W)) u_dec (
    .size_i   (size_i),
    .mask_o   (mask),
    .msb_oh_o (msb_oh)
  );

  assign st_in[0] = operand_i & mask;
  assign st_c[0]  = c_i;

  for (genvar g = 0; g < MAX_STEP; g++) begin : g_step
    shrot_step #(.W(LONG_W)) u_step (
      .a_i      (st_in[g]),
      .mask_i   (mask),
      .msb_oh_i (msb_oh),
      .op_i     (op_i),
      .c_i      (st_c[g]),
      .res_o    (st_in[g+1]),
      .c_o      (st_c[g+1]),
      .v_o      (st_v[g])
    );
  end

  assign two_step = ctrl_i[DIST_BIT];
  assign res_d    = two_step ? st_in[2] : st_in[1];
  assign c_d      = two_step ? st_c[2]  : st_c[1];
  // sign changed in either step
  assign v_d      = two_step ? (st_v[0] | st_v[1]) : st_v[0];

  shrot_flags #(.W(LONG_W)) u_flags (
    .res_i    (res_d),
    .mask_i   (mask),
    .msb_oh_i (msb_oh),
    .n_o      (n_d),
    .z_o      (z_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      n_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      c_o      <= 1'b0;
    end else begin
      result_o <= res_d;
      n_o      <= n_d;
      z_o      <= z_d;
      v_o      <= v_d;
      c_o      <= c_d;
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int LONG_W = 32,
  parameter int CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LONG_W-1:0] operand_i,
  input logic [1:0]        size_i,
  input logic [2:0]        op_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              c_i,
  input logic [LONG_W-1:0] result_o,
  input logic              n_o,
  input logic              z_o,
  input logic              v_o,
  input logic              c_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !n_o && !z_o && !v_o && !c_o));

  p_lsl_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0) |=> !v_o);

  p_lsr_top_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && size_i == 2'd0) |=> !result_o[7]);

  p_asr_keeps_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && size_i == 2'd0) |=> (result_o[7] == $past(operand_i[7])));

  p_rol_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4) |=> (c_o == result_o[0]));

  p_rcl_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd6) |=> !v_o);

  p_byte_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd0) |=> (result_o[LONG_W-1:8] == '0));

  p_zero_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (z_o == (result_o == '0)));

  p_long_sign_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i[1]) |=> (n_o == result_o[LONG_W-1]));
endmodule

bind shrot_unit shrot_unit_chk #(.LONG_W(LONG_W), .CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  size = '0;
  logic [2:0]  op = '0;
  logic [7:0]  ctrl = '0;
  logic        cin = 1'b0;
  logic [31:0] result;
  logic        n_f, z_f, v_f, c_f;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  shrot_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .operand_i(operand), .size_i(size),
    .op_i(op), .ctrl_i(ctrl), .c_i(cin),
    .result_o(result), .n_o(n_f), .z_o(z_f), .v_o(v_f), .c_o(c_f)
  );

  function automatic logic [35:0] model(input logic [2:0] o, input logic [1:0] s,
                                        input logic ci, input logic two,
                                        input logic [31:0] a);
    int w;
    logic [31:0] msk, x;
    logic c, v, top, bot;
    w   = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    msk = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 1);
    x   = a & msk;
    c   = ci;
    v   = 1'b0;
    for (int k = 0; k < (two ? 2 : 1); k++) begin
      top = x[w-1];
      bot = x[0];
      case (o)
        3'd0: begin x = x << 1; c = top; end
        3'd1: begin x = x >> 1; c = bot; end
        3'd2: begin if (x[w-2] != top) v = 1'b1; x = x << 1; c = top; end
        3'd3: begin x = x >> 1; x[w-1] = top; c = bot; end
        3'd4: begin x = x << 1; x[0] = top; c = top; end
        3'd5: begin x = x >> 1; x[w-1] = bot; c = bot; end
        3'd6: begin x = x << 1; x[0] = c; c = top; end
        default: begin x = x >> 1; x[w-1] = c; c = bot; end
      endcase
      x = x & msk;
    end
    return {x[w-1], (x == 32'd0), v, c, x};
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [2:0] o, input logic [1:0] s,
                     input logic ci, input logic [7:0] ct, input logic [31:0] a);
    logic [35:0] e;
    string t;
    @(negedge clk);
    operand = a; size = s; op = o; ctrl = ct; cin = ci;
    e = model(o, s, ci, ct[6], a);
    t = (tag == "") ? op_tag(o) : tag;
    @(negedge clk);
    check(t, "result", result, e[31:0]);
    check(t, "v/c", {30'd0, v_f, c_f}, {30'd0, e[33], e[32]});
    check((tag == "") ? "R10" : tag, "n/z", {30'd0, n_f, z_f}, {30'd0, e[35], e[34]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] e;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset result", result, 32'd0);
    check("R1", "reset flags", {28'd0, n_f, z_f, v_f, c_f}, 32'd0);
    rst_n = 1'b1;

    // R1 latency: output holds until the next edge
    run("R1", 3'd0, 2'd0, 1'b0, 8'h00, 32'h0000_0081);
    @(negedge clk);
    operand = 32'h0000_0003; op = 3'd0; size = 2'd0; ctrl = 8'h00;
    @(posedge clk); #1;
    e = model(3'd0, 2'd0, 1'b0, 1'b0, 32'h3);
    check("R1", "one-cycle result", result, e[31:0]);

    // R2 distance bit and ignored ctrl bits
    run("R2", 3'd0, 2'd0, 1'b0, 8'h40, 32'h0000_00c1);
    run("R2", 3'd0, 2'd0, 1'b0, 8'hbf, 32'h0000_00c1);
    run("R2", 3'd7, 2'd1, 1'b1, 8'hff, 32'h0000_0001);

    // R5 sign-change overflow corners
    run("R5", 3'd2, 2'd0, 1'b0, 8'h00, 32'h0000_0060);
    run("R5", 3'd2, 2'd0, 1'b0, 8'h00, 32'h0000_0020);
    run("R5", 3'd2, 2'd0, 1'b0, 8'h40, 32'h0000_0020);
    run("R5", 3'd2, 2'd2, 1'b0, 8'h40, 32'he000_0000);
    run("R5", 3'd2, 2'd1, 1'b0, 8'h40, 32'h0000_c000);

    // R6 sign replication, R8 carry entry
    run("R6", 3'd3, 2'd1, 1'b0, 8'h40, 32'h0000_8001);
    run("R8", 3'd6, 2'd2, 1'b1, 8'h00, 32'h8000_0000);
    run("R8", 3'd6, 2'd2, 1'b1, 8'h40, 32'h8000_0000);
    run("R7", 3'd5, 2'd0, 1'b0, 8'h40, 32'h0000_0002);

    // R9 junk above size, size code 3
    run("R9", 3'd4, 2'd0, 1'b0, 8'h00, 32'hdead_be80);
    run("R9", 3'd1, 2'd1, 1'b0, 8'h40, 32'hffff_0003);
    run("R9", 3'd4, 2'd3, 1'b0, 8'h00, 32'h8000_0001);

    // R10 zero and negative
    run("R10", 3'd0, 2'd0, 1'b0, 8'h00, 32'h0000_0080);
    run("R10", 3'd1, 2'd1, 1'b0, 8'h40, 32'h0000_0003);

    for (int i = 0; i < 3000; i++)
      run("", 3'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), $urandom);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule